// File: doc/BRIEF.md
# Wakeup Clock Source Sequencer

This block decides which oscillator feeds the system clock multiplexer before, during and after low-power modes. Software asks for a new source by writing a 2-bit code. The sequencer moves the select over only after the target oscillator reports stable. On deep-sleep entry it stores the source that was in use. On deep-sleep exit it either runs at once from the internal RC oscillator and hands back to the stored source later (fast wakeup), or keeps the stored source selected and waits for it to become stable. A power-down wakeup carries a reset, so it always drops the system onto the internal RC oscillator.

The select code drives an external glitch-free clock multiplexer. A second output, one cycle later, reports the source the multiplexer has taken over. A busy flag is high while the sequencer waits on an oscillator. Source codes are 00 for the internal RC oscillator, 01 for the external crystal and 10 for the PLL. Code 11 is unused. Bit n of the stable input belongs to the source with code n.

The state machine has five states:
- RUN: the current source is selected and the machine is idle.
- SWITCH: the machine waits for a software-requested target to become stable.
- SLEEP: deep sleep is in progress.
- WAKE_WAIT: a slow exit is waiting for the stored source.
- HANDBACK: the system runs on RC while the stored source starts.

The transitions are:
- RUN goes to SLEEP on sleep entry.
- RUN goes to SWITCH when a held request names another source.
- SWITCH goes to RUN when the target is stable.
- SLEEP goes to RUN on a fast exit when the stored source is RC.
- SLEEP goes to HANDBACK on a fast exit when the stored source is not RC.
- SLEEP goes to WAKE_WAIT on a slow exit.
- WAKE_WAIT goes to RUN when the stored source is stable.
- HANDBACK goes to RUN when the stored source is stable.
- Every state goes to RUN on RC when a power-down wakeup arrives.

Top module: `clk_src_seq`

## Requirements
- R1: After reset, clk_sel and active_src are 00 (RC) and busy is 0.
- R2: A write of code 00, 01 or 10 in RUN naming a different source raises busy two cycles after the write and keeps clk_sel on the old source until stable bit n of the target (code n) is 1; clk_sel then changes to the target and busy falls on the same edge. A write of 11 is ignored.
- R3: active_src equals clk_sel delayed by one clock.
- R4: A sleep-entry pulse in RUN stores the current source, and clk_sel holds that source unchanged for the whole of SLEEP.
- R5: A fast exit (fast_wake_en=1) whose stored source is 01 or 10 sets clk_sel to 00 with busy=1 on the next edge. The machine stays there until the stored source's stable bit is 1, then selects it with busy=0.
- R6: A fast exit whose stored source is 00 returns straight to RUN on RC with busy=0.
- R7: A slow exit (fast_wake_en=0) keeps clk_sel on the stored source with busy=1 until that source's stable bit is 1, then clears busy.
- R8: pd_wake in any state gives clk_sel=00 and busy=0 on the next edge and discards any held request. It takes priority over all other inputs.
- R9: A valid write made while busy or sleeping is held, with the latest write winning. It is applied only after the machine returns to RUN.
- R10: A sleep-entry pulse outside RUN is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_we | input | 1 | Software write strobe for a new source |
| req_src | input | 2 | Requested source code |
| src_stable | input | 3 | Per-source stable flags, bit n for code n |
| sleep_enter | input | 1 | Deep-sleep entry pulse |
| sleep_exit | input | 1 | Deep-sleep exit pulse |
| pd_wake | input | 1 | Wakeup from power-down (implies reset of clock choice) |
| fast_wake_en | input | 1 | Run on RC immediately at deep-sleep exit |
| clk_sel | output | 2 | Select code to the clock multiplexer |
| active_src | output | 2 | Source now driving the system, one cycle after clk_sel |
| busy | output | 1 | Waiting on an oscillator to become stable |

## Verification
The bench sweeps every pre-sleep source against both fast-wakeup settings. While the stored source is held unstable it checks that the select neither leaves RC too early nor restores a source that is still starting. A design that skipped the handshake would hand back to a source that is still starting. A design that forgot the stored source would wake onto the wrong oscillator.

Further cases cover:
- a request written during handback, which must wait and then apply; applying it early would switch away before the restore;
- a power-down wakeup that lands during handback with a request held, which must discard the request;
- a sleep pulse that lands during a switch, which must be ignored;
- the unused code 11.

// File: rtl/clk_seq_pkg.sv
package clk_seq_pkg;
    localparam logic [1:0] SRC_RC   = 2'b00;
    localparam logic [1:0] SRC_XTAL = 2'b01;
    localparam logic [1:0] SRC_PLL  = 2'b10;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_SWITCH,
        ST_SLEEP,
        ST_WAKE_WAIT,
        ST_HANDBACK
    } seq_state_e;
endpackage

// File: rtl/clk_seq_req.sv
module clk_seq_req #(
    parameter int NSRC  = 3,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_src,
    input  logic             take,
    input  logic             flush,
    output logic             pend_valid,
    output logic [SEL_W-1:0] pend_src
);
    logic code_ok;
    assign code_ok = (int'(wr_src) < NSRC);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_src   <= '0;
        end else if (flush) begin
            pend_valid <= 1'b0;
        end else if (wr_en && code_ok) begin
            pend_valid <= 1'b1;
            pend_src   <= wr_src;
        end else if (take) begin
            pend_valid <= 1'b0;
        end
    end

    // R9
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_valid && !take && !flush) |=> pend_valid);
endmodule

// File: rtl/clk_seq_fsm.sv
module clk_seq_fsm
    import clk_seq_pkg::*;
#(
    parameter int NSRC  = 3,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_stable,
    input  logic             sleep_enter,
    input  logic             sleep_exit,
    input  logic             pd_wake,
    input  logic             fast_wake_en,
    input  logic             pend_valid,
    input  logic [SEL_W-1:0] pend_src,
    output logic             take,
    output logic             flush,
    output logic [SEL_W-1:0] clk_sel,
    output logic             busy
);
    localparam logic [SEL_W-1:0] RC_CODE = SEL_W'(SRC_RC);

    seq_state_e       state_q, state_n;
    logic [SEL_W-1:0] cur_q, cur_n;
    logic [SEL_W-1:0] saved_q, saved_n;
    logic [SEL_W-1:0] tgt_q, tgt_n;

    function automatic logic is_stable(input logic [NSRC-1:0] s, input logic [SEL_W-1:0] c);
        logic r;
        r = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (int'(c) == i) r = s[i];
        end
        return r;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cur_q   <= RC_CODE;
            saved_q <= RC_CODE;
            tgt_q   <= RC_CODE;
        end else begin
            state_q <= state_n;
            cur_q   <= cur_n;
            saved_q <= saved_n;
            tgt_q   <= tgt_n;
        end
    end

    always_comb begin
        state_n = state_q;
        cur_n   = cur_q;
        saved_n = saved_q;
        tgt_n   = tgt_q;
        take    = 1'b0;
        flush   = pd_wake;
        if (pd_wake) begin
            state_n = ST_RUN;
            cur_n   = RC_CODE;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (sleep_enter) begin
                        saved_n = cur_q;
                        state_n = ST_SLEEP;
                    end else if (pend_valid) begin
                        take = 1'b1;
                        if (pend_src != cur_q) begin
                            tgt_n   = pend_src;
                            state_n = ST_SWITCH;
                        end
                    end
                end
                ST_SWITCH: begin
                    if (is_stable(src_stable, tgt_q)) begin
                        cur_n   = tgt_q;
                        state_n = ST_RUN;
                    end
                end
                ST_SLEEP: begin
                    if (sleep_exit) begin
                        if (!fast_wake_en) begin
                            state_n = ST_WAKE_WAIT;
                        end else begin
                            cur_n   = RC_CODE;
                            state_n = (saved_q == RC_CODE) ? ST_RUN : ST_HANDBACK;
                        end
                    end
                end
                ST_WAKE_WAIT, ST_HANDBACK: begin
                    if (is_stable(src_stable, saved_q)) begin
                        cur_n   = saved_q;
                        state_n = ST_RUN;
                    end
                end
                default: state_n = ST_RUN;
            endcase
        end
    end

    always_comb begin
        clk_sel = cur_q;
        busy    = 1'b0;
        unique case (state_q)
            ST_RUN:       begin clk_sel = cur_q;   busy = 1'b0; end
            ST_SWITCH:    begin clk_sel = cur_q;   busy = 1'b1; end
            ST_SLEEP:     begin clk_sel = saved_q; busy = 1'b0; end
            ST_WAKE_WAIT: begin clk_sel = saved_q; busy = 1'b1; end
            ST_HANDBACK:  begin clk_sel = RC_CODE; busy = 1'b1; end
            default:      begin clk_sel = RC_CODE; busy = 1'b0; end
        endcase
    end

    // R8
    pd_force_rc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pd_wake |=> (clk_sel == RC_CODE && !busy));

    // R2
    sel_needs_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel != $past(clk_sel) && clk_sel != RC_CODE && !$past(pd_wake))
        |-> ((($past(src_stable)) >> clk_sel) & NSRC'(1)) != '0);

    // R4
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && $past(state_q) == ST_SLEEP) |-> $stable(clk_sel));

    // R10
    sleep_only_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && $past(state_q) != ST_SLEEP) |-> $past(state_q) == ST_RUN);
endmodule

// File: rtl/clk_src_seq.sv
module clk_src_seq #(
    parameter int NSRC  = 3,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_we,
    input  logic [SEL_W-1:0] req_src,
    input  logic [NSRC-1:0]  src_stable,
    input  logic             sleep_enter,
    input  logic             sleep_exit,
    input  logic             pd_wake,
    input  logic             fast_wake_en,
    output logic [SEL_W-1:0] clk_sel,
    output logic [SEL_W-1:0] active_src,
    output logic             busy
);
    logic             pend_valid, take, flush;
    logic [SEL_W-1:0] pend_src;

    clk_seq_req #(.NSRC(NSRC), .SEL_W(SEL_W)) u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (req_we),
        .wr_src     (req_src),
        .take       (take),
        .flush      (flush),
        .pend_valid (pend_valid),
        .pend_src   (pend_src)
    );

    clk_seq_fsm #(.NSRC(NSRC), .SEL_W(SEL_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_stable   (src_stable),
        .sleep_enter  (sleep_enter),
        .sleep_exit   (sleep_exit),
        .pd_wake      (pd_wake),
        .fast_wake_en (fast_wake_en),
        .pend_valid   (pend_valid),
        .pend_src     (pend_src),
        .take         (take),
        .flush        (flush),
        .clk_sel      (clk_sel),
        .busy         (busy)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) active_src <= '0;
        else        active_src <= clk_sel;
    end

    // R3
    active_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active_src == $past(clk_sel));
endmodule

// File: tb/clk_src_seq_test.sv
module clk_src_seq_test;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_we = 1'b0;
    logic [1:0] req_src = 2'b00;
    logic [2:0] src_stable = 3'b111;
    logic       sleep_enter = 1'b0;
    logic       sleep_exit = 1'b0;
    logic       pd_wake = 1'b0;
    logic       fast_wake_en = 1'b0;
    logic [1:0] clk_sel, active_src;
    logic       busy;

    int n_run = 0;
    int n_fail = 0;
    logic [1:0] model_cur = 2'b00;

    clk_src_seq uut (
        .clk(clk), .rst_n(rst_n), .req_we(req_we), .req_src(req_src),
        .src_stable(src_stable), .sleep_enter(sleep_enter), .sleep_exit(sleep_exit),
        .pd_wake(pd_wake), .fast_wake_en(fast_wake_en),
        .clk_sel(clk_sel), .active_src(active_src), .busy(busy)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [1:0] sel_e, input logic busy_e);
        n_run++;
        if (clk_sel !== sel_e || busy !== busy_e) begin
            n_fail++;
            $display("FAIL %s: clk_sel=%0d busy=%0d expected clk_sel=%0d busy=%0d",
                     req, clk_sel, busy, sel_e, busy_e);
        end
    endtask

    task automatic chk_act(input string req, input logic [1:0] exp);
        n_run++;
        if (active_src !== exp) begin
            n_fail++;
            $display("FAIL %s: active_src=%0d expected %0d", req, active_src, exp);
        end
    endtask

    task automatic write(input logic [1:0] code);
        req_src = code; req_we = 1'b1;
        step(1);
        req_we = 1'b0;
    endtask

    task automatic pulse_pd();
        pd_wake = 1'b1; step(1); pd_wake = 1'b0;
        model_cur = 2'b00;
    endtask

    // Switch to src with all sources stable (R2, R3)
    task automatic go_to(input logic [1:0] s);
        logic [1:0] old;
        old = model_cur;
        write(s);
        step(1);
        chk("R2 busy while switching", old, s != old);
        step(1);
        chk("R2 switched", s, 1'b0);
        chk_act("R3 lag", old);
        step(1);
        chk_act("R3 follow", s);
        model_cur = s;
    endtask

    initial begin
        #(PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        step(2);
        chk("R1 reset", 2'b00, 1'b0);
        chk_act("R1 reset active", 2'b00);
        rst_n = 1'b1;
        step(2);
        chk("R1 after release", 2'b00, 1'b0);

        // Sweep every pre-sleep source against both wakeup modes
        for (int s = 0; s < 3; s++) begin
            for (int f = 0; f < 2; f++) begin
                src_stable = 3'b111;
                pulse_pd();
                if (s != 0) go_to(2'(s));
                if (s != 0) src_stable[s] = 1'b0;
                sleep_enter = 1'b1; step(1); sleep_enter = 1'b0;
                chk("R4 sleep keeps source", 2'(s), 1'b0);
                step(3);
                chk("R4 sleep hold", 2'(s), 1'b0);
                fast_wake_en = f[0];
                sleep_exit = 1'b1; step(1); sleep_exit = 1'b0;
                if (f == 1) chk(s == 0 ? "R6 fast exit RC" : "R5 fast exit on RC", 2'b00, s != 0);
                else        chk("R7 slow exit waits", 2'(s), 1'b1);
                step(3);
                if (s == 0) chk(f == 1 ? "R6 settled" : "R7 settled RC", 2'b00, 1'b0);
                else if (f == 1) chk("R5 hold until stable", 2'b00, 1'b1);
                else chk("R7 hold until stable", 2'(s), 1'b1);
                src_stable = 3'b111;
                step(1);
                chk(f == 1 ? "R5 handback" : "R7 released", 2'(s), 1'b0);
                model_cur = 2'(s);
            end
        end

        // R2: unused code ignored
        write(2'b11);
        step(4);
        chk("R2 code 11 ignored", model_cur, 1'b0);

        // R2: target unstable keeps old select
        pulse_pd();
        src_stable = 3'b011;
        write(2'b10);
        step(4);
        chk("R2 wait for unstable target", 2'b00, 1'b1);
        src_stable = 3'b111;
        step(1);
        chk("R2 switch on stable", 2'b10, 1'b0);
        model_cur = 2'b10;

        // R9: request during handback held, latest wins
        src_stable = 3'b011;
        sleep_enter = 1'b1; step(1); sleep_enter = 1'b0;
        fast_wake_en = 1'b1;
        sleep_exit = 1'b1; step(1); sleep_exit = 1'b0;
        write(2'b00);
        write(2'b01);
        step(2);
        chk("R9 held during handback", 2'b00, 1'b1);
        src_stable = 3'b111;
        step(1);
        chk("R9 handback first", 2'b10, 1'b0);
        step(1);
        chk("R9 held request starts", 2'b10, 1'b1);
        step(1);
        chk("R9 latest request applied", 2'b01, 1'b0);
        model_cur = 2'b01;

        // R8: pd_wake during handback discards held request
        go_to(2'b10);
        src_stable = 3'b011;
        sleep_enter = 1'b1; step(1); sleep_enter = 1'b0;
        sleep_exit = 1'b1; step(1); sleep_exit = 1'b0;
        write(2'b01);
        pd_wake = 1'b1; sleep_enter = 1'b1; step(1); pd_wake = 1'b0; sleep_enter = 1'b0;
        model_cur = 2'b00;
        chk("R8 pd_wake forces RC", 2'b00, 1'b0);
        src_stable = 3'b111;
        step(4);
        chk("R8 request discarded", 2'b00, 1'b0);

        // R8: pd_wake from running PLL
        go_to(2'b10);
        pulse_pd();
        chk("R8 from run", 2'b00, 1'b0);

        // R10: sleep pulse during switch ignored
        go_to(2'b01);
        src_stable = 3'b011;
        write(2'b10);
        step(1);
        sleep_enter = 1'b1; step(1); sleep_enter = 1'b0;
        chk("R10 still switching", 2'b01, 1'b1);
        src_stable = 3'b111;
        step(1);
        chk("R10 switch completes", 2'b10, 1'b0);
        model_cur = 2'b10;
        write(2'b00);
        step(2);
        chk("R10 not sleeping, request applied", 2'b00, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule